// File: doc/BRIEF.md
# TLB Entry Permission Checker

This combinational block takes one translation entry that a lookup has already selected and decides whether an access may use it. The entry describes an even/odd pair of adjacent pages. Each half carries its own frame number, its valid and dirty flags, its privilege level and its inhibit and privilege-mode bits. The page size either comes with the entry or comes from a shared page-size setting. The block picks the half that the virtual address falls in and resolves the faults in a fixed priority. On success it forms the physical address and the read, write and execute rights.

The block sits between the translation storage and the exception logic of a core's memory pipeline. The storage and the search that finds the entry stay outside. So do fault delivery and refill. All results depend only on the current inputs.

Top module: `tlb_perm_check`

## Requirements
- R1: The page-size shift is `ent_ps_i` when `ent_idx_i >= FA_BASE` (the fully associative region), and `sa_ps_i` otherwise. Shifts lie in 12..30.
- R2: Bit number PS of `va_i` selects the half: 1 selects the `hi_*` (odd) half and 0 selects the `lo_*` (even) half.
- R3: When `mode64_i` is 0, the selected half's no-execute, no-read and exact-privilege bits act as 0.
- R4: A selected half with valid = 0 yields fault code 1 (invalid), whatever the other inputs are.
- R5: Access codes are 0 = fetch, 1 = load and 2 = store. A fetch with no-execute set yields code 2. A load with no-read set yields code 3. Both rank below invalid.
- R6: With exact-privilege = 0, the fault is code 4 when `cur_plv_i` is greater than the entry level. With exact-privilege = 1, the fault is code 4 when the two levels differ. This check ranks below codes 1 to 3.
- R7: A store to a half with dirty = 0 yields code 5, the lowest-ranked fault.
- R8: On a match (code 0), bits PS and above of `pa_o` are the frame number shifted left by 12, with frame bits 0..PS-13 cleared. Bits below PS are copied from `va_i`.
- R9: On a match, read is 1, write equals the half's dirty bit, and execute is the inverse of the effective no-execute bit.
- R10: On any fault, `pa_o` and all three permission outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ent_idx_i | input | IDX_W | Index of the matched entry |
| ent_ps_i | input | PS_W | Page-size shift held in the entry |
| sa_ps_i | input | PS_W | Shared page-size shift for the set-associative region |
| va_i | input | VA_W | Virtual address |
| acc_i | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| cur_plv_i | input | 2 | Current privilege level |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| lo_ppn_i | input | PPN_W | Even half frame number |
| lo_v_i | input | 1 | Even half valid |
| lo_d_i | input | 1 | Even half dirty (writable) |
| lo_plv_i | input | 2 | Even half privilege level |
| lo_nx_i | input | 1 | Even half no-execute |
| lo_nr_i | input | 1 | Even half no-read |
| lo_rplv_i | input | 1 | Even half exact-privilege select |
| hi_ppn_i | input | PPN_W | Odd half frame number |
| hi_v_i | input | 1 | Odd half valid |
| hi_d_i | input | 1 | Odd half dirty (writable) |
| hi_plv_i | input | 2 | Odd half privilege level |
| hi_nx_i | input | 1 | Odd half no-execute |
| hi_nr_i | input | 1 | Odd half no-read |
| hi_rplv_i | input | 1 | Odd half exact-privilege select |
| fault_o | output | 3 | 0 match, 1 invalid, 2 exec-inhibit, 3 read-inhibit, 4 privilege, 5 dirty |
| pa_o | output | PA_W | Physical address (0 on fault) |
| perm_r_o | output | 1 | Read allowed |
| perm_w_o | output | 1 | Write allowed |
| perm_x_o | output | 1 | Execute allowed |

## Verification
The central risk is that several fault conditions hold at once. For example, a store that is under-privileged and also hits a clean page must report only the higher-ranked fault. Directed vectors set every condition together and then remove them one at a time, so each step of the ranking is shown to win over the next. Random vectors draw all inhibit, privilege and dirty bits freely in both word modes, so overlaps also occur widely. Each result is compared with a bench model that applies the ranking independently.

// File: rtl/tlb_perm_pkg.sv
package tlb_perm_pkg;

   localparam int PLV_W = 2;

   typedef enum logic [2:0] {
      FLT_MATCH   = 3'd0,
      FLT_INVALID = 3'd1,
      FLT_XI      = 3'd2,
      FLT_RI      = 3'd3,
      FLT_PE      = 3'd4,
      FLT_DIRTY   = 3'd5
   } fault_e;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } access_e;

   typedef struct packed {
      logic             v;
      logic             d;
      logic [PLV_W-1:0] plv;
      logic             nx;
      logic             nr;
      logic             rplv;
   } attr_t;

endpackage

// File: rtl/tlb_half_pick.sv
module tlb_half_pick
   import tlb_perm_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PPN_W   = 36,
   parameter int PS_W    = 6,
   parameter int IDX_W   = 12,
   parameter int FA_BASE = 2048
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic [PS_W-1:0]  ent_ps_i,
   input  logic [PS_W-1:0]  sa_ps_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic             mode64_i,
   input  attr_t            lo_attr_i,
   input  attr_t            hi_attr_i,
   input  logic [PPN_W-1:0] lo_ppn_i,
   input  logic [PPN_W-1:0] hi_ppn_i,
   output logic [PS_W-1:0]  ps_o,
   output attr_t            attr_o,
   output logic [PPN_W-1:0] ppn_o
);

   localparam logic [IDX_W-1:0] FA_START = IDX_W'(FA_BASE);

   logic  in_fa;
   logic  odd;
   attr_t raw;

   assign in_fa = (idx_i >= FA_START);
   assign ps_o  = in_fa ? ent_ps_i : sa_ps_i;
   assign odd   = |((va_i >> ps_o) & VA_W'(1));
   assign raw   = odd ? hi_attr_i : lo_attr_i;
   assign ppn_o = odd ? hi_ppn_i : lo_ppn_i;

   always_comb begin
      attr_o = raw;
      if (!mode64_i) begin
         attr_o.nx   = 1'b0;
         attr_o.nr   = 1'b0;
         attr_o.rplv = 1'b0;
      end
   end

   always_comb begin
      if (!mode64_i)
         AST_NARROW_CLEARS: assert (!attr_o.nx && !attr_o.nr && !attr_o.rplv)
            else $error("narrow mode leaked an extended bit"); // R3
   end

endmodule

// File: rtl/tlb_fault_rank.sv
module tlb_fault_rank
   import tlb_perm_pkg::*;
(
   input  attr_t            attr_i,
   input  access_e          acc_i,
   input  logic [PLV_W-1:0] cur_plv_i,
   output fault_e           fault_o
);

   logic priv_bad;

   assign priv_bad = attr_i.rplv ? (cur_plv_i != attr_i.plv)
                                 : (cur_plv_i >  attr_i.plv);

   always_comb begin
      if (!attr_i.v)
         fault_o = FLT_INVALID;
      else if (acc_i == ACC_FETCH && attr_i.nx)
         fault_o = FLT_XI;
      else if (acc_i == ACC_LOAD && attr_i.nr)
         fault_o = FLT_RI;
      else if (priv_bad)
         fault_o = FLT_PE;
      else if (acc_i == ACC_STORE && !attr_i.d)
         fault_o = FLT_DIRTY;
      else
         fault_o = FLT_MATCH;
   end

   always_comb begin
      if (!attr_i.v)
         AST_INVALID_WINS: assert (fault_o == FLT_INVALID)
            else $error("invalid half not ranked first"); // R4
   end

endmodule

// File: rtl/tlb_pa_form.sv
module tlb_pa_form #(
   parameter int VA_W  = 48,
   parameter int PA_W  = 48,
   parameter int PPN_W = 36,
   parameter int PS_W  = 6
) (
   input  logic [VA_W-1:0]  va_i,
   input  logic [PPN_W-1:0] ppn_i,
   input  logic [PS_W-1:0]  ps_i,
   output logic [PA_W-1:0]  pa_o
);

   localparam int PG_SHIFT = 12;

   for (genvar i = 0; i < PA_W; i++) begin : g_bit
      localparam bit HAS_VA  = (i < VA_W);
      localparam bit HAS_PPN = (i >= PG_SHIFT) && (i - PG_SHIFT < PPN_W);
      logic va_b;
      logic ppn_b;
      if (HAS_VA) begin : g_va
         assign va_b = va_i[i];
      end else begin : g_nova
         assign va_b = 1'b0;
      end
      if (HAS_PPN) begin : g_ppn
         assign ppn_b = ppn_i[i-PG_SHIFT];
      end else begin : g_noppn
         assign ppn_b = 1'b0;
      end
      assign pa_o[i] = (32'(i) < 32'(ps_i)) ? va_b : ppn_b;
   end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
   import tlb_perm_pkg::*;
#(
   parameter int VA_W    = 48,
   parameter int PA_W    = 48,
   parameter int PPN_W   = PA_W - 12,
   parameter int PS_W    = 6,
   parameter int IDX_W   = 12,
   parameter int FA_BASE = 2048
) (
   input  logic [IDX_W-1:0] ent_idx_i,
   input  logic [PS_W-1:0]  ent_ps_i,
   input  logic [PS_W-1:0]  sa_ps_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic [1:0]       acc_i,
   input  logic [1:0]       cur_plv_i,
   input  logic             mode64_i,
   input  logic [PPN_W-1:0] lo_ppn_i,
   input  logic             lo_v_i,
   input  logic             lo_d_i,
   input  logic [1:0]       lo_plv_i,
   input  logic             lo_nx_i,
   input  logic             lo_nr_i,
   input  logic             lo_rplv_i,
   input  logic [PPN_W-1:0] hi_ppn_i,
   input  logic             hi_v_i,
   input  logic             hi_d_i,
   input  logic [1:0]       hi_plv_i,
   input  logic             hi_nx_i,
   input  logic             hi_nr_i,
   input  logic             hi_rplv_i,
   output logic [2:0]       fault_o,
   output logic [PA_W-1:0]  pa_o,
   output logic             perm_r_o,
   output logic             perm_w_o,
   output logic             perm_x_o
);

   if (PA_W <= 12) begin : g_bad_pa
      $error("PA_W must exceed the 4 KiB page offset");
   end
   if ((1 << PS_W) <= 30) begin : g_bad_ps
      $error("PS_W too narrow for shifts up to 30");
   end
   if (FA_BASE >= (1 << IDX_W)) begin : g_bad_base
      $error("FA_BASE outside the index range");
   end
   if (VA_W <= 30) begin : g_bad_va
      $error("VA_W must cover the largest page shift");
   end

   attr_t             lo_attr, hi_attr, sel_attr;
   logic [PS_W-1:0]   ps;
   logic [PPN_W-1:0]  ppn;
   logic [PA_W-1:0]   pa_raw;
   fault_e            fault;
   logic              hit;

   assign lo_attr = '{v: lo_v_i, d: lo_d_i, plv: lo_plv_i,
                      nx: lo_nx_i, nr: lo_nr_i, rplv: lo_rplv_i};
   assign hi_attr = '{v: hi_v_i, d: hi_d_i, plv: hi_plv_i,
                      nx: hi_nx_i, nr: hi_nr_i, rplv: hi_rplv_i};

   tlb_half_pick #(
      .VA_W(VA_W), .PPN_W(PPN_W), .PS_W(PS_W),
      .IDX_W(IDX_W), .FA_BASE(FA_BASE)
   ) i_pick (
      .idx_i     (ent_idx_i),
      .ent_ps_i  (ent_ps_i),
      .sa_ps_i   (sa_ps_i),
      .va_i      (va_i),
      .mode64_i  (mode64_i),
      .lo_attr_i (lo_attr),
      .hi_attr_i (hi_attr),
      .lo_ppn_i  (lo_ppn_i),
      .hi_ppn_i  (hi_ppn_i),
      .ps_o      (ps),
      .attr_o    (sel_attr),
      .ppn_o     (ppn)
   );

   tlb_fault_rank i_rank (
      .attr_i    (sel_attr),
      .acc_i     (access_e'(acc_i)),
      .cur_plv_i (cur_plv_i),
      .fault_o   (fault)
   );

   tlb_pa_form #(
      .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .PS_W(PS_W)
   ) i_pa (
      .va_i  (va_i),
      .ppn_i (ppn),
      .ps_i  (ps),
      .pa_o  (pa_raw)
   );

   assign hit      = (fault == FLT_MATCH);
   assign fault_o  = fault;
   assign pa_o     = hit ? pa_raw : '0;
   assign perm_r_o = hit;
   assign perm_w_o = hit & sel_attr.d;
   assign perm_x_o = hit & ~sel_attr.nx;

   logic [PA_W-1:0] low_mask;
   logic [PA_W-1:0] va_ext;
   assign low_mask = (PA_W'(1) << ps) - PA_W'(1);
   assign va_ext   = PA_W'(va_i);

   always_comb begin
      if (fault_o == 3'd5)
         AST_DIRTY_ONLY_STORE: assert (acc_i == 2'd2)
            else $error("dirty fault on a non-store"); // R7
      if (fault_o == 3'd2)
         AST_XI_ONLY_FETCH64: assert (acc_i == 2'd0 && mode64_i)
            else $error("exec-inhibit outside 64-bit fetch"); // R5
      if (perm_r_o)
         AST_PA_LOW_FROM_VA: assert (((pa_o ^ va_ext) & low_mask) == '0)
            else $error("page offset not taken from va"); // R8
      if (fault_o != 3'd0)
         AST_FAULT_ZEROES: assert (pa_o == '0 && !perm_r_o && !perm_w_o && !perm_x_o)
            else $error("outputs not cleared on fault"); // R10
      if (fault_o == 3'd0)
         AST_MATCH_READS: assert (perm_r_o)
            else $error("match without read right"); // R9
   end

endmodule

// File: tb/test_tlb_perm_check.sv
module test_tlb_perm_check;

   localparam int FA_BASE = 2048;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   always #10 clk = ~clk;

   logic [11:0] idx;
   logic [5:0]  ent_ps, sa_ps;
   logic [47:0] va;
   logic [1:0]  acc, cur_plv;
   logic        mode64;
   logic [35:0] lo_ppn, hi_ppn;
   logic        lo_v, lo_d, lo_nx, lo_nr, lo_rplv;
   logic        hi_v, hi_d, hi_nx, hi_nr, hi_rplv;
   logic [1:0]  lo_plv, hi_plv;
   logic [2:0]  fault;
   logic [47:0] pa;
   logic        pr, pw, px;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   tlb_perm_check i_tlb_perm_check (
      .ent_idx_i(idx), .ent_ps_i(ent_ps), .sa_ps_i(sa_ps), .va_i(va),
      .acc_i(acc), .cur_plv_i(cur_plv), .mode64_i(mode64),
      .lo_ppn_i(lo_ppn), .lo_v_i(lo_v), .lo_d_i(lo_d), .lo_plv_i(lo_plv),
      .lo_nx_i(lo_nx), .lo_nr_i(lo_nr), .lo_rplv_i(lo_rplv),
      .hi_ppn_i(hi_ppn), .hi_v_i(hi_v), .hi_d_i(hi_d), .hi_plv_i(hi_plv),
      .hi_nx_i(hi_nx), .hi_nr_i(hi_nr), .hi_rplv_i(hi_rplv),
      .fault_o(fault), .pa_o(pa), .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px)
   );

   function automatic logic [53:0] model();
      int          ps;
      logic        odd, v, d, nx, nr, rp;
      logic [1:0]  pl;
      logic [63:0] pn, p;
      logic [2:0]  f;
      ps  = (idx >= 12'(FA_BASE)) ? int'(ent_ps) : int'(sa_ps);
      odd = va[ps];
      v  = odd ? hi_v : lo_v;       d  = odd ? hi_d : lo_d;
      nx = odd ? hi_nx : lo_nx;     nr = odd ? hi_nr : lo_nr;
      rp = odd ? hi_rplv : lo_rplv; pl = odd ? hi_plv : lo_plv;
      pn = 64'(odd ? hi_ppn : lo_ppn);
      if (!mode64) begin nx = 0; nr = 0; rp = 0; end
      if (!v)                                        f = 3'd1;
      else if (acc == 2'd0 && nx)                    f = 3'd2;
      else if (acc == 2'd1 && nr)                    f = 3'd3;
      else if ((!rp && cur_plv > pl) || (rp && cur_plv != pl)) f = 3'd4;
      else if (acc == 2'd2 && !d)                    f = 3'd5;
      else                                           f = 3'd0;
      pn = pn & ~((64'd1 << (ps - 12)) - 64'd1);
      p  = (pn << 12) | (64'(va) & ((64'd1 << ps) - 64'd1));
      if (f != 3'd0) return {f, 48'd0, 3'b000};
      return {f, p[47:0], 1'b1, d, ~nx};
   endfunction

   task automatic check(input string req);
      logic [53:0] exp_v, act_v;
      #2;
      exp_v = model();
      act_v = {fault, pa, pr, pw, px};
      vectors++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s: got fault=%0d pa=%h rwx=%b, expected fault=%0d pa=%h rwx=%b",
                  req, act_v[53:51], act_v[50:3], act_v[2:0],
                  exp_v[53:51], exp_v[50:3], exp_v[2:0]);
      end
   endtask

   task automatic clear_all();
      idx = 12'd0; ent_ps = 6'd12; sa_ps = 6'd12; va = '0; acc = 2'd1;
      cur_plv = 2'd0; mode64 = 1'b1;
      lo_ppn = '0; lo_v = 1; lo_d = 1; lo_plv = 2'd3; lo_nx = 0; lo_nr = 0; lo_rplv = 0;
      hi_ppn = '0; hi_v = 1; hi_d = 1; hi_plv = 2'd3; hi_nx = 0; hi_nr = 0; hi_rplv = 0;
   endtask

   task automatic randomize_all();
      idx    = 12'($urandom % (FA_BASE + 64));
      ent_ps = 6'(12 + $urandom % 19);
      sa_ps  = 6'(12 + $urandom % 19);
      va     = {16'($urandom), 32'($urandom)};
      acc    = 2'($urandom % 3);
      cur_plv = 2'($urandom);
      mode64 = 1'($urandom);
      lo_ppn = {4'($urandom), 32'($urandom)};
      hi_ppn = {4'($urandom), 32'($urandom)};
      {lo_v, lo_d, lo_nx, lo_nr, lo_rplv, lo_plv} = 7'($urandom);
      {hi_v, hi_d, hi_nx, hi_nr, hi_rplv, hi_plv} = 7'($urandom);
      if ($urandom % 4 != 0) begin lo_v = 1; hi_v = 1; end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_all();
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // reset-state vector: all-zero address, valid clean-read entry -> match R9
      @(negedge clk); check("R9");

      // R1: index below the region uses the shared shift, at the boundary the entry's shift
      @(negedge clk); clear_all();
      idx = 12'(FA_BASE - 1); sa_ps = 6'd14; ent_ps = 6'd20;
      va = 48'h0000_0000_4000; lo_v = 0; check("R1");
      @(negedge clk); idx = 12'(FA_BASE); check("R1");

      // R2: half select follows bit PS
      @(negedge clk); clear_all();
      sa_ps = 6'd16; lo_ppn = 36'h111; hi_ppn = 36'h222; va = 48'h0000_0001_0123;
      check("R2");
      @(negedge clk); va = 48'h0000_0000_0123; check("R2");

      // R3: narrow mode ignores no-exec, no-read, exact privilege
      @(negedge clk); clear_all();
      mode64 = 0; acc = 2'd0; lo_nx = 1; lo_nr = 1; lo_rplv = 1; cur_plv = 2'd0;
      check("R3");
      @(negedge clk); acc = 2'd1; check("R3");

      // R4: invalid outranks every other condition
      @(negedge clk); clear_all();
      lo_v = 0; lo_nx = 1; lo_nr = 1; lo_d = 0; lo_plv = 0; cur_plv = 3; acc = 2'd0;
      check("R4");

      // R5: exec and read inhibit outrank privilege
      @(negedge clk); clear_all();
      acc = 2'd0; lo_nx = 1; lo_nr = 1; lo_plv = 0; cur_plv = 3; check("R5");
      @(negedge clk); acc = 2'd1; check("R5");

      // R6: privilege in both modes, and over dirty
      @(negedge clk); clear_all();
      lo_plv = 2; cur_plv = 1; acc = 2'd1; check("R6");
      @(negedge clk); lo_rplv = 1; check("R6");
      @(negedge clk); lo_rplv = 0; cur_plv = 3; acc = 2'd2; lo_d = 0; check("R6");
      @(negedge clk); lo_rplv = 1; cur_plv = 2; check("R7");

      // R7: clean page store
      @(negedge clk); clear_all(); acc = 2'd2; lo_d = 0; check("R7");

      // R8: software bits of the frame cleared, large page
      @(negedge clk); clear_all();
      sa_ps = 6'd30; lo_ppn = '1; va = 48'h0000_2ABC_DEF1; check("R8");
      @(negedge clk); sa_ps = 6'd12; va = 48'hFFFF_FFFF_EFFF; hi_ppn = 36'h9_8765_4321; check("R8");

      // R9: rights on match
      @(negedge clk); clear_all(); lo_d = 0; lo_nx = 1; check("R9");

      // R10: outputs cleared on fault
      @(negedge clk); clear_all(); lo_ppn = '1; va = 48'h123; lo_plv = 0; cur_plv = 1; check("R10");

      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         randomize_all();
         check("R6_R8_R9");
      end

      done = 1;
      finish_run();
   end

endmodule